// File: doc/BRIEF.md
# Grouped Port Change Interrupt Detector

This block watches two four-bit general-purpose ports as one group of eight candidate pins and raises a single port interrupt request when the group leaves its idle level in a selected direction. Each pin's direction-control bit decides whether it takes part. Only pins configured as inputs are eligible. Ineligible pins are pinned to the idle level inside the block, so they never disturb detection.

The eligible pins are synchronized and then merged into one "group active" signal. Edge detection runs on that merged signal and not on each pin, so a request cannot fire again until every eligible pin has returned to idle. A detected edge sets a sticky request flag. The flag stays set until software pulses a clear strobe, and a separate enable gates the flag onto the interrupt line. Changes to the direction bits or the edge select re-seed the detector, so reconfiguration never creates a request of its own.

Top module: `grp_pin_chg_irq`

## Requirements
- R1: The eight candidates are `port_b_pin[3:0]` and `port_c_pin[3:0]`. Any of them can raise the request on its own.
- R2: A pin takes part only when its direction bit is 0 (input). A pin whose direction bit is 1 (output) never raises or blocks a request.
- R3: With `rise_sel` = 1 the idle level is low. The group is active when any eligible pin is high, and a change from no eligible pin high to some eligible pin high sets the flag.
- R4: With `rise_sel` = 0 the idle level is high. The group is active when any eligible pin is low, and a change from all eligible pins high to some eligible pin low sets the flag.
- R5: After the group becomes active, a further pin leaving idle raises no new request. Re-arming needs every eligible pin back at idle.
- R6: `irq_out` is high exactly when `irq_flag` is high and `irq_en` is high. The flag sets regardless of `irq_en`.
- R7: `irq_flag` stays set until a cycle with `flag_clr` high. When a new edge and `flag_clr` fall in the same cycle, the flag stays set.
- R8: A change of `rise_sel` or any direction bit raises no request by itself, even when it makes the group active.
- R9: After reset `irq_flag` and `irq_out` are 0. A pin change driven before clock edge k shows on `irq_flag` after clock edge k+3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_b_pin | input | 4 | Raw pin levels, port B |
| port_c_pin | input | 4 | Raw pin levels, port C |
| port_b_dir | input | 4 | Direction bits for port B, 1 = output |
| port_c_dir | input | 4 | Direction bits for port C, 1 = output |
| rise_sel | input | 1 | 1 = rising detection, 0 = falling detection |
| irq_en | input | 1 | Gates the flag onto irq_out |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| irq_flag | output | 1 | Sticky request flag |
| irq_out | output | 1 | Gated interrupt line |

## Verification
The clear strobe and a freshly detected group edge can land in the same clock cycle. The bench sets the flag, returns all pins to idle, and then drives a new active pin. It counts the synchronizer and combine registers to find the exact cycle in which the edge reaches the flag, and raises `flag_clr` for that edge only. The flag must read 1 afterwards. A separate plain clear pulse must then bring it to 0, and this also confirms the R9 latency.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_mode_e;

  // Level a pin rests at when no event is pending in the given mode.
  function automatic logic idle_level(input edge_mode_e mode);
    return (mode == EDGE_FALL);
  endfunction

endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcd_combine.sv
module pcd_combine
  import pcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] pins,
  input  logic [W-1:0] dir_out,
  input  edge_mode_e   mode,
  output logic         group_active
);
  // A pin counts as active when it is eligible and away from idle.
  function automatic logic any_away(input logic [W-1:0] p,
                                    input logic [W-1:0] d,
                                    input logic         idle);
    logic [W-1:0] away;
    away = (p ^ {W{idle}}) & ~d;
    return |away;
  endfunction

  assign group_active = any_away(pins, dir_out, idle_level(mode));
endmodule

// File: rtl/pcd_edge_flag.sv
module pcd_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic act_now,
  input  logic reseed,
  input  logic flag_clr,
  output logic edge_pulse,
  output logic flag
);
  logic act_q;
  logic prev_q;

  // Both start as "active" so nothing can fire before the pins settle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      act_q  <= act_now;
      prev_q <= reseed ? act_now : act_q;
    end
  end

  assign edge_pulse = act_q & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (edge_pulse) flag <= 1'b1;
    else if (flag_clr)   flag <= 1'b0;
  end
endmodule

// File: rtl/grp_pin_chg_irq.sv
module grp_pin_chg_irq
  import pcd_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_b_pin,
  input  logic [PORT_W-1:0] port_c_pin,
  input  logic [PORT_W-1:0] port_b_dir,
  input  logic [PORT_W-1:0] port_c_dir,
  input  logic              rise_sel,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              irq_flag,
  output logic              irq_out
);
  localparam int NPIN = 2 * PORT_W;

  logic [NPIN-1:0] raw_pins;
  logic [NPIN-1:0] sync_pins;
  logic [NPIN-1:0] dir_all;
  logic [NPIN-1:0] dir_q;
  edge_mode_e      mode;
  edge_mode_e      mode_q;
  logic            group_active;
  logic            cfg_chg;
  logic            edge_pulse;

  assign raw_pins = {port_c_pin, port_b_pin};
  assign dir_all  = {port_c_dir, port_b_dir};
  assign mode     = edge_mode_e'(rise_sel);

  pcd_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(sync_pins)
  );

  pcd_combine #(.W(NPIN)) u_comb (
    .pins(sync_pins), .dir_out(dir_all), .mode(mode),
    .group_active(group_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mode_q <= EDGE_RISE;
    end else begin
      dir_q  <= dir_all;
      mode_q <= mode;
    end
  end

  assign cfg_chg = (dir_q != dir_all) || (mode_q != mode);

  pcd_edge_flag u_edge (
    .clk(clk), .rst_n(rst_n), .act_now(group_active), .reseed(cfg_chg),
    .flag_clr(flag_clr), .edge_pulse(edge_pulse), .flag(irq_flag)
  );

  assign irq_out = irq_flag & irq_en;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker (
  input logic clk,
  input logic rst_n,
  input logic irq_flag,
  input logic irq_out,
  input logic irq_en,
  input logic flag_clr,
  input logic edge_pulse,
  input logic cfg_chg
);
  a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> irq_flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !edge_pulse) |=> !irq_flag);
  a_r5_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);
  a_r8_reseed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !edge_pulse);
  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_out);
  a_r6_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && irq_flag) |-> irq_out);
endmodule

bind grp_pin_chg_irq pcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .irq_out(irq_out),
  .irq_en(irq_en), .flag_clr(flag_clr), .edge_pulse(edge_pulse),
  .cfg_chg(cfg_chg)
);

// File: tb/grp_pin_chg_irq_tb.sv
module grp_pin_chg_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pb = '0, pc = '0, db = '0, dc = '0;
  logic       rise = 1'b1, en = 1'b0, clr = 1'b0;
  logic       flag, iout;
  int         n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  grp_pin_chg_irq dut_i (
    .clk(clk), .rst_n(rst_n), .port_b_pin(pb), .port_c_pin(pc),
    .port_b_dir(db), .port_c_dir(dc), .rise_sel(rise), .irq_en(en),
    .flag_clr(clr), .irq_flag(flag), .irq_out(iout)
  );

  // Bench model: group active when some input pin sits off its idle level.
  function automatic logic model_active(input logic [7:0] p,
                                        input logic [7:0] d,
                                        input logic r);
    logic any = 1'b0;
    for (int i = 0; i < 8; i++)
      if (d[i] == 1'b0 && p[i] == r) any = 1'b1;
    return any;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
  endtask

  task automatic set_pins(input logic [7:0] v);
    {pc, pb} = v;
  endtask

  task automatic go_idle(input logic r);
    set_pins(r ? 8'h00 : 8'hFF);
    {dc, db} = 8'h00;
    rise = r;
    cyc(6);
    pulse_clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R9 reset flag", flag, 1'b0);
    chk("R9 reset irq_out", iout, 1'b0);
    rst_n = 1'b1;
    cyc(6);
    chk("R9 idle after reset", flag, 1'b0);

    // R1 R2 R3 R4 R6: sweep mode x pin x direction
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < 8; p++) begin
        for (int o = 0; o < 2; o++) begin
          logic [7:0] pins, dirs;
          logic expf;
          go_idle(r[0]);
          dirs = 8'h00;
          dirs[p] = o[0];
          {dc, db} = dirs;
          en = p[0];
          cyc(4);
          pins = r[0] ? 8'h00 : 8'hFF;
          pins[p] = r[0];
          set_pins(pins);
          cyc(6);
          expf = model_active(pins, dirs, r[0]);
          chk(r[0] ? "R3 R1 R2 rise pin" : "R4 R1 R2 fall pin", flag, expf);
          chk("R6 gate", iout, expf & en);
        end
      end
    end

    // R6: flag sets while disabled, then shows when enabled
    go_idle(1'b1);
    en = 1'b0;
    set_pins(8'h10);
    cyc(6);
    chk("R6 flag without enable", flag, 1'b1);
    chk("R6 line low without enable", iout, 1'b0);
    en = 1'b1; cyc(1);
    chk("R6 line after enable", iout, 1'b1);

    // R5: no re-arm in rising mode
    go_idle(1'b1);
    set_pins(8'h01); cyc(6);
    chk("R5 first rise", flag, 1'b1);
    pulse_clr();
    set_pins(8'h03); cyc(6);
    chk("R5 second pin blocked", flag, 1'b0);
    set_pins(8'h02); cyc(6);
    chk("R5 partial return blocked", flag, 1'b0);
    set_pins(8'h00); cyc(6);
    set_pins(8'h04); cyc(6);
    chk("R5 re-armed rise", flag, 1'b1);

    // R5: no re-arm in falling mode
    go_idle(1'b0);
    set_pins(8'hFE); cyc(6);
    chk("R5 first fall", flag, 1'b1);
    pulse_clr();
    set_pins(8'h7E); cyc(6);
    chk("R5 fall second pin blocked", flag, 1'b0);
    set_pins(8'hFF); cyc(6);
    set_pins(8'hBF); cyc(6);
    chk("R5 re-armed fall", flag, 1'b1);

    // R8: direction change exposes an active pin, no request
    go_idle(1'b1);
    db = 4'b0001; cyc(4);
    set_pins(8'h01); cyc(6);
    chk("R8 output pin high", flag, 1'b0);
    db = 4'b0000; cyc(6);
    chk("R8 dir change no request", flag, 1'b0);
    // R8: mode change with all pins low
    rise = 1'b0; set_pins(8'h00); cyc(6);
    chk("R8 mode change no request", flag, 1'b0);

    // R7 R9: exact latency and clear colliding with a new edge
    go_idle(1'b1);
    set_pins(8'h80); cyc(6);
    set_pins(8'h00); cyc(6);
    chk("R7 flag held after pins idle", flag, 1'b1);
    set_pins(8'h20);
    cyc(3);
    chk("R9 not yet set", 1'b1, flag); // flag still held from before
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk("R7 edge beats clear", flag, 1'b1);
    pulse_clr();
    chk("R7 plain clear", flag, 1'b0);
    set_pins(8'h00); cyc(6);
    set_pins(8'h02);
    cyc(3);
    chk("R9 flag not before edge k+3", flag, 1'b0);
    cyc(1);
    chk("R9 flag after edge k+3", flag, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule